// File: doc/BRIEF.md
# Nested Exception Priority Arbiter

This block holds the per-vector state of an exception controller and decides, every cycle, which exception should be taken next. Vector numbers below 16 are internal exceptions; the numbers from 16 up to `NUM_VEC-1` are external interrupt lines. Each vector has a priority, an enable flag, a pending flag and an active flag. External vectors also register the level of their interrupt line. Vectors 1, 2 and 3 have fixed negative priorities (-3, -2, -1) and are always enabled.

A single-cycle configuration port sets and clears the enable and pending flags, writes priorities and writes a 3-bit grouping field. The grouping field splits each priority into a group part and a subpriority part. The block continuously drives several outputs: the winning pending vector, that vector's group priority, and the group priority of the most urgent active exception. From the last two it raises a preemption request. A `take` strobe moves the winning vector from pending to active. A `ret` strobe retires an active vector.

Top module: `epa_arbiter`

## Requirements
- R1: After reset all pending and active flags are clear, `pend_valid` and `preempt` are 0 and `act_grp` reads 256.
- R2: Vectors 1, 2 and 3 read priorities -3, -2 and -1, ignore priority writes and are always enabled. Vector 0 never becomes pending.
- R3: A priority write to vector 4 or above keeps only the upper `PRIO_BITS` bits of the 8-bit value. `rd_prio` returns the stored value with the lower bits zero, and a two's-complement value for vectors 1 to 3.
- R4: `pend_vec` names the pending, enabled vector with the smallest priority value. When two vectors have the same priority, the lower vector number wins. `pend_valid` is 1 exactly when such a vector exists. A disabled vector never wins.
- R5: With grouping field g (0 to 7), bits g down to 0 of a priority form the subpriority and the group priority is the priority with those bits cleared. Negative priorities are their own group priority. `pend_grp` is the group priority of `pend_vec`. Among vectors with equal group priority, the one with the lower subpriority wins.
- R6: `act_grp` is the smallest group priority among active vectors, or 256 when none is active. It follows later changes of the grouping field.
- R7: `preempt` is 1 exactly when `pend_valid` is 1 and `pend_grp` is strictly less than `act_grp`. Equal group priorities do not preempt.
- R8: A `take` strobe while `pend_valid` is 1 sets the active flag and clears the pending flag of `pend_vec` at the next edge. A `ret` strobe clears the active flag of `ret_vec`.
- R9: For an external vector k, `irq_lvl[k-16]` is registered into its level flag. While that flag is 1, the pending flag is set at the next edge, and this set overrides a pending-clear written in the same cycle. Internal vectors have no level flag.
- R10: Configuration opcodes: 0 sets enable, 1 clears enable, 2 sets pending, 3 clears pending, 4 writes priority, 5 writes the grouping field from `cfg_data[2:0]`. Opcodes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Configuration opcode (R10) |
| cfg_vec | input | VW | Target vector of the write |
| cfg_data | input | 8 | Priority value or grouping field |
| irq_lvl | input | NUM_VEC-16 | Levels of the external interrupt lines |
| take | input | 1 | Move the winning vector to active |
| ret | input | 1 | Retire an active vector |
| ret_vec | input | VW | Vector to retire |
| rd_vec | input | VW | Vector whose priority is read |
| rd_prio | output | 10 | Signed priority of `rd_vec` |
| pend_valid | output | 1 | A pending, enabled vector exists |
| pend_vec | output | VW | Winning pending vector |
| pend_grp | output | 10 | Signed group priority of `pend_vec` |
| act_grp | output | 10 | Signed group priority of the most urgent active vector |
| preempt | output | 1 | Preemption request |

## Verification
The bench targets tie-breaking. A design that compares only group priorities, or that resolves ties toward the higher vector number, picks the wrong vector when two vectors share a group value. Equal group priorities between the pending and the active side are also checked, because an off-by-one compare would raise `preempt` there. The bench writes priorities to the fixed vectors and pends vector 0: a missing write guard would either overwrite -2 or produce a spurious winner. It also holds an interrupt line high while clearing its pending flag, and retires active vectors one at a time, so that an idle value other than 256 or a reversed set/clear order shows up on `act_grp`, `preempt` or `pend_vec`.

// File: rtl/epa_pkg.sv
package epa_pkg;
   typedef logic signed [9:0] prio_t;

   localparam prio_t PRIO_IDLE = 10'sd256;

   typedef enum logic [2:0] {
      OP_EN_SET   = 3'd0,
      OP_EN_CLR   = 3'd1,
      OP_PEND_SET = 3'd2,
      OP_PEND_CLR = 3'd3,
      OP_PRIO_WR  = 3'd4,
      OP_GRP_WR   = 3'd5
   } cfg_op_t;

   function automatic prio_t group_of(input prio_t p, input logic [2:0] g);
      logic [9:0] sub_mask;
      sub_mask = (10'd2 << g) - 10'd1;
      if (p < 0) return p;
      return prio_t'(p & prio_t'(~sub_mask));
   endfunction
endpackage

// File: rtl/epa_vec_store.sv
module epa_vec_store
   import epa_pkg::*;
#(
   parameter int NUM_VEC   = 48,
   parameter int PRIO_BITS = 3,
   localparam int VW       = $clog2(NUM_VEC),
   localparam int NUM_EXT  = NUM_VEC - 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_op,
   input  logic [VW-1:0]      cfg_vec,
   input  logic [7:0]         cfg_data,
   input  logic [NUM_EXT-1:0] irq_lvl,
   input  logic               take,
   input  logic [VW-1:0]      take_vec,
   input  logic               ret,
   input  logic [VW-1:0]      ret_vec,
   output logic [NUM_VEC-1:0] pend_q,
   output logic [NUM_VEC-1:0] en_q,
   output logic [NUM_VEC-1:0] act_q,
   output prio_t              eff_prio [NUM_VEC],
   output logic [2:0]         grp_q
);
   localparam logic [7:0] PMASK = 8'hFF << (8 - PRIO_BITS);

   logic [NUM_VEC-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) grp_q <= '0;
      else if (cfg_we && cfg_op == OP_GRP_WR) grp_q <= cfg_data[2:0];
   end

   for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
      logic hit;
      assign hit = cfg_we && (cfg_vec == VW'(i));

      if (i >= 16) begin : g_ext
         always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[i] <= 1'b0;
            else        lvl_q[i] <= irq_lvl[i-16];
         end
      end else begin : g_int
         assign lvl_q[i] = 1'b0;
      end

      if (i == 0) begin : g_none
         assign pend_q[i]   = 1'b0;
         assign act_q[i]    = 1'b0;
         assign en_q[i]     = 1'b0;
         assign eff_prio[i] = '0;
      end else begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q[i] <= 1'b0;
               act_q[i]  <= 1'b0;
            end else begin
               if (hit && cfg_op == OP_PEND_CLR) pend_q[i] <= 1'b0;
               if (hit && cfg_op == OP_PEND_SET) pend_q[i] <= 1'b1;
               if (take && take_vec == VW'(i))   pend_q[i] <= 1'b0;
               if (lvl_q[i])                     pend_q[i] <= 1'b1;
               if (ret && ret_vec == VW'(i))     act_q[i]  <= 1'b0;
               if (take && take_vec == VW'(i))   act_q[i]  <= 1'b1;
            end
         end

         if (i <= 3) begin : g_fixed
            assign en_q[i]     = 1'b1;
            assign eff_prio[i] = prio_t'(i - 4);
         end else begin : g_prog
            logic [7:0] prio_q;
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  en_q[i] <= 1'b0;
                  prio_q  <= '0;
               end else if (hit) begin
                  if (cfg_op == OP_EN_SET)  en_q[i] <= 1'b1;
                  if (cfg_op == OP_EN_CLR)  en_q[i] <= 1'b0;
                  if (cfg_op == OP_PRIO_WR) prio_q  <= cfg_data & PMASK;
               end
            end
            assign eff_prio[i] = prio_t'({2'b00, prio_q});
         end

         if (i >= 16) begin : g_lvl_chk
            a_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
               lvl_q[i] |=> pend_q[i]);
         end
      end
   end

   a_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_vec != '0 && !(ret && ret_vec == take_vec)) |=> act_q[$past(take_vec)]);
endmodule

// File: rtl/epa_select.sv
module epa_select
   import epa_pkg::*;
#(
   parameter int NUM_VEC = 48,
   localparam int VW     = $clog2(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] pend_q,
   input  logic [NUM_VEC-1:0] en_q,
   input  logic [NUM_VEC-1:0] act_q,
   input  prio_t              eff_prio [NUM_VEC],
   input  logic [2:0]         grp_q,
   output logic               pend_valid,
   output logic [VW-1:0]      pend_vec,
   output prio_t              pend_grp,
   output prio_t              act_grp
);
   prio_t best_p;

   always_comb begin
      pend_valid = 1'b0;
      pend_vec   = '0;
      best_p     = PRIO_IDLE;
      act_grp    = PRIO_IDLE;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (pend_q[i] && en_q[i] && (!pend_valid || eff_prio[i] < best_p)) begin
            pend_valid = 1'b1;
            pend_vec   = VW'(i);
            best_p     = eff_prio[i];
         end
         if (act_q[i] && group_of(eff_prio[i], grp_q) < act_grp)
            act_grp = group_of(eff_prio[i], grp_q);
      end
      pend_grp = group_of(best_p, grp_q);
   end

   a_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (pend_q[pend_vec] && en_q[pend_vec]));

   a_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == '0) |-> (act_grp == PRIO_IDLE));
endmodule

// File: rtl/epa_arbiter.sv
module epa_arbiter
   import epa_pkg::*;
#(
   parameter int NUM_VEC   = 48,
   parameter int PRIO_BITS = 3,
   localparam int VW       = $clog2(NUM_VEC),
   localparam int NUM_EXT  = NUM_VEC - 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_op,
   input  logic [VW-1:0]      cfg_vec,
   input  logic [7:0]         cfg_data,
   input  logic [NUM_EXT-1:0] irq_lvl,
   input  logic               take,
   input  logic               ret,
   input  logic [VW-1:0]      ret_vec,
   input  logic [VW-1:0]      rd_vec,
   output logic [9:0]         rd_prio,
   output logic               pend_valid,
   output logic [VW-1:0]      pend_vec,
   output logic [9:0]         pend_grp,
   output logic [9:0]         act_grp,
   output logic               preempt
);
   if (NUM_VEC < 17 || NUM_VEC > 512) begin : g_bad_num_vec
      $error("epa_arbiter: NUM_VEC must lie in 17..512");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio_bits
      $error("epa_arbiter: PRIO_BITS must lie in 1..8");
   end

   logic [NUM_VEC-1:0] pend_q, en_q, act_q;
   prio_t              eff_prio [NUM_VEC];
   logic [2:0]         grp_q;
   prio_t              pend_grp_s, act_grp_s;

   epa_vec_store #(.NUM_VEC(NUM_VEC), .PRIO_BITS(PRIO_BITS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_vec(cfg_vec), .cfg_data(cfg_data),
      .irq_lvl(irq_lvl),
      .take(take && pend_valid), .take_vec(pend_vec),
      .ret(ret), .ret_vec(ret_vec),
      .pend_q(pend_q), .en_q(en_q), .act_q(act_q),
      .eff_prio(eff_prio), .grp_q(grp_q)
   );

   epa_select #(.NUM_VEC(NUM_VEC)) u_select (
      .clk(clk), .rst_n(rst_n),
      .pend_q(pend_q), .en_q(en_q), .act_q(act_q),
      .eff_prio(eff_prio), .grp_q(grp_q),
      .pend_valid(pend_valid), .pend_vec(pend_vec),
      .pend_grp(pend_grp_s), .act_grp(act_grp_s)
   );

   assign pend_grp = pend_grp_s;
   assign act_grp  = act_grp_s;
   assign preempt  = pend_valid && (pend_grp_s < act_grp_s);
   assign rd_prio  = (int'(rd_vec) < NUM_VEC) ? eff_prio[rd_vec] : '0;

   a_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && pend_vec == VW'(2)) |-> (pend_grp_s == -10'sd2));
endmodule

// File: tb/epa_arbiter_tb.sv
module epa_arbiter_tb;
   localparam int NUM_VEC = 48;
   localparam int VW      = $clog2(NUM_VEC);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [2:0]        cfg_op = '0;
   logic [VW-1:0]     cfg_vec = '0;
   logic [7:0]        cfg_data = '0;
   logic [NUM_VEC-17:0] irq_lvl = '0;
   logic              take = 1'b0;
   logic              ret = 1'b0;
   logic [VW-1:0]     ret_vec = '0;
   logic [VW-1:0]     rd_vec = '0;
   logic [9:0]        rd_prio, pend_grp, act_grp;
   logic              pend_valid, preempt;
   logic [VW-1:0]     pend_vec;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   epa_arbiter #(.NUM_VEC(NUM_VEC), .PRIO_BITS(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
      .cfg_vec(cfg_vec), .cfg_data(cfg_data), .irq_lvl(irq_lvl),
      .take(take), .ret(ret), .ret_vec(ret_vec), .rd_vec(rd_vec),
      .rd_prio(rd_prio), .pend_valid(pend_valid), .pend_vec(pend_vec),
      .pend_grp(pend_grp), .act_grp(act_grp), .preempt(preempt)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(input int op, input int vec, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_op = 3'(op); cfg_vec = VW'(vec); cfg_data = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_take();
      @(negedge clk); take = 1'b1;
      @(negedge clk); take = 1'b0;
   endtask

   task automatic do_ret(input int vec);
      @(negedge clk); ret = 1'b1; ret_vec = VW'(vec);
      @(negedge clk); ret = 1'b0;
   endtask

   task automatic read_prio(input int vec, output int p);
      @(negedge clk); rd_vec = VW'(vec);
      #1 p = int'($signed(rd_prio));
   endtask

   task automatic t_reset();
      chk("R1 pend_valid", int'(pend_valid), 0);
      chk("R1 act_grp", int'($signed(act_grp)), 256);
      chk("R1 preempt", int'(preempt), 0);
   endtask

   task automatic t_fixed();
      int p;
      read_prio(1, p); chk("R2 vec1 prio", p, -3);
      read_prio(3, p); chk("R2 vec3 prio", p, -1);
      cfg(4, 2, 8'h40);
      read_prio(2, p); chk("R2 vec2 write ignored", p, -2);
      cfg(2, 0, 0);
      chk("R2 vec0 never pends", int'(pend_valid), 0);
   endtask

   task automatic t_prio_bits();
      int p;
      cfg(4, 5, 8'hFF);
      read_prio(5, p); chk("R3 low bits zero", p, 224);
      cfg(4, 6, 8'h3F);
      read_prio(6, p); chk("R3 low bits dropped", p, 32);
   endtask

   task automatic t_pick();
      cfg(0, 20, 0); cfg(0, 21, 0); cfg(0, 23, 0);
      cfg(4, 20, 8'h80); cfg(4, 21, 8'h40); cfg(4, 23, 8'h40); cfg(4, 22, 8'h00);
      cfg(2, 20, 0); cfg(2, 21, 0); cfg(2, 22, 0); cfg(2, 23, 0);
      chk("R4 winner lowest value, tie to lower vector", int'(pend_vec), 21);
      chk("R4 pend_grp", int'($signed(pend_grp)), 64);
   endtask

   task automatic t_group();
      cfg(5, 0, 5);
      cfg(4, 21, 8'h60);
      chk("R5 subpriority breaks group tie", int'(pend_vec), 23);
      chk("R5 group of winner", int'($signed(pend_grp)), 64);
   endtask

   task automatic t_preempt();
      do_take();
      chk("R8 act_grp after take", int'($signed(act_grp)), 64);
      chk("R8 next winner", int'(pend_vec), 21);
      chk("R7 equal group no preempt", int'(preempt), 0);
      cfg(5, 0, 4);
      chk("R5 group field 4", int'($signed(pend_grp)), 96);
      chk("R7 lower urgency no preempt", int'(preempt), 0);
      cfg(2, 3, 0);
      chk("R4 negative wins", int'(pend_vec), 3);
      chk("R5 negative group", int'($signed(pend_grp)), -1);
      chk("R7 preempt raised", int'(preempt), 1);
      do_take();
      chk("R6 act_grp nested", int'($signed(act_grp)), -1);
      chk("R7 no preempt under fault", int'(preempt), 0);
      do_ret(3);
      chk("R8 ret restores act_grp", int'($signed(act_grp)), 64);
      do_ret(23);
      chk("R6 idle act_grp", int'($signed(act_grp)), 256);
      chk("R7 preempt when idle", int'(preempt), 1);
   endtask

   task automatic t_enable_ops();
      cfg(1, 21, 0);
      chk("R4 disabled vector skipped", int'(pend_vec), 20);
      cfg(6, 20, 0);
      cfg(7, 20, 0);
      chk("R10 opcodes 6/7 ignored", int'(pend_vec), 20);
      chk("R10 pend still valid", int'(pend_valid), 1);
   endtask

   task automatic t_level();
      cfg(3, 20, 0); cfg(3, 21, 0); cfg(3, 22, 0);
      chk("R10 pending clear", int'(pend_valid), 0);
      cfg(0, 30, 0);
      @(negedge clk); irq_lvl[14] = 1'b1;
      @(negedge clk);
      chk("R9 one cycle: not yet pending", int'(pend_valid), 0);
      @(negedge clk);
      chk("R9 level pends vector", int'(pend_vec), 30);
      cfg(3, 30, 0);
      chk("R9 level set beats clear", int'(pend_valid), 1);
      @(negedge clk); irq_lvl[14] = 1'b0;
      @(negedge clk); @(negedge clk);
      cfg(3, 30, 0);
      chk("R9 clear after line low", int'(pend_valid), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed();
      t_prio_bits();
      t_pick();
      t_group();
      t_preempt();
      t_enable_ops();
      t_level();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule